// File: doc/BRIEF.md
# Byte-Swapping I/O Port Bridge

This block connects a CPU's physical address space to a 16-bit, little-endian legacy I/O port space. A CPU request whose address falls in a fixed 64 KB window is turned into exactly one port access. The port number is the low 16 bits of the CPU address. Requests may be byte, halfword or word sized. Both sides use a request/acknowledge handshake. The CPU request is held until the bridge acknowledges it. The port-side request is held until the device returns a single-cycle acknowledge.

A static configuration input tells the bridge that the CPU is big-endian. In that mode, halfword and word data are byte-reversed in both directions, so that multi-byte port values keep their numeric meaning. Byte data is never reordered. Requests outside the window, and requests with the reserved size code, are left unanswered so that another decoder on the CPU bus can respond to them.

The control is a three-state machine:
- **IDLE** goes to **ISSUE** when a claimed request is seen. This is the *claim* transition, and it latches the port address, direction, size and lane-arranged write data.
- **ISSUE** drives the port request. It goes to **RESPOND** when the port acknowledges. This is the *complete* transition, and it latches the lane-arranged read data.
- **RESPOND** holds the CPU acknowledge. It goes back to **IDLE** once the CPU drops its request. This is the *release* transition.

Top module: `isa_io_bridge`

## Requirements
- R1: A request is claimed only when cpu_addr[31:16] equals 16'h1400 and cpu_size is not 3. Any other request never raises io_req or cpu_ack while it is held.
- R2: io_port equals cpu_addr[15:0] of the claimed request.
- R3: The size code is 0 for a byte, 1 for a halfword, 2 for a word and 3 for reserved (not claimed). io_size and io_we repeat the CPU's size and direction.
- R4: With big_endian low, data passes unchanged in both directions. Lanes above the access size are zero: bits 31:8 for a byte, bits 31:16 for a halfword.
- R5: With big_endian high, a halfword is swapped in both directions. Bits 15:8 and 7:0 exchange places, and the upper half is zero.
- R6: With big_endian high, a word is fully byte-reversed in both directions. Byte 0 exchanges with byte 3, and byte 1 with byte 2.
- R7: A byte access uses bits 7:0 unchanged, whatever the value of big_endian.
- R8: io_req rises in the cycle after the claim. io_req stays high, with its address, size and data stable, until the cycle in which io_ack is seen.
- R9: cpu_ack rises only in the cycle after an io_ack. cpu_ack stays high while cpu_req is held. Each request produces exactly one port access.
- R10: During and right after reset, io_req and cpu_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static setting: CPU is big-endian, so swap data lanes |
| cpu_req | input | 1 | CPU request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data, right-aligned |
| cpu_ack | output | 1 | Request complete, held while cpu_req is high |
| cpu_rdata | output | 32 | Read data, valid while cpu_ack is high |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | Port access direction |
| io_size | output | 2 | Port access size code |
| io_port | output | 16 | Port number |
| io_wdata | output | 32 | Port write data, little-endian lanes |
| io_ack | input | 1 | One-cycle completion pulse from the port side |
| io_rdata | input | 32 | Port read data, sampled with io_ack |

## Verification
The hardest case to reach is a CPU that keeps its request high while a slow device delays io_ack for several cycles. The bridge must not issue a second port access, either during that wait or after it acknowledges. The bench reaches this case with a directed access that holds io_ack back for three cycles. It then keeps cpu_req high for extra cycles after cpu_ack, and watches io_req stay low. Unclaimed requests are also held for many cycles, both just below and just above the window and with the reserved size code, to show that no side effect appears.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_HALF = 2'd1,
        XFER_WORD = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_RESPOND = 2'd2
    } seq_state_e;

endpackage

// File: rtl/isa_window_decode.sv
module isa_window_decode #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16,
    parameter logic [ADDR_W-1:0] WINDOW_BASE = 32'h1400_0000
) (
    input  logic [ADDR_W-1:0]        addr,
    input  isa_bridge_pkg::xfer_size_e size,
    output logic                     hit,
    output logic [PORT_W-1:0]        port
);
    import isa_bridge_pkg::*;

    localparam int TAG_W = ADDR_W - PORT_W;
    localparam logic [TAG_W-1:0] BASE_TAG = WINDOW_BASE[ADDR_W-1:PORT_W];

    logic tag_match;

    always_comb begin
        tag_match = (addr[ADDR_W-1:PORT_W] == BASE_TAG);
        hit       = tag_match && (size != XFER_RSVD);
        port      = addr[PORT_W-1:0];
    end

endmodule

// File: rtl/isa_lane_shuffle.sv
module isa_lane_shuffle #(
    parameter int DATA_W = 32
) (
    input  logic                       swap,
    input  isa_bridge_pkg::xfer_size_e size,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout
);
    import isa_bridge_pkg::*;

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] reversed;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign reversed[g*8 +: 8] = din[(LANES-1-g)*8 +: 8];
        end
    endgenerate

    always_comb begin
        dout = '0;
        unique case (size)
            XFER_BYTE: dout[7:0]  = din[7:0];
            XFER_HALF: dout[15:0] = swap ? {din[7:0], din[15:8]} : din[15:0];
            XFER_WORD: dout       = swap ? reversed : din;
            default:   dout       = '0;
        endcase
    end

endmodule

// File: rtl/isa_bridge_seq.sv
module isa_bridge_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic hit,
    input  logic io_ack,
    output logic io_req,
    output logic cpu_ack,
    output logic load_req,
    output logic load_rsp
);
    import isa_bridge_pkg::*;

    seq_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (cpu_req && hit) state_nxt = ST_ISSUE;
            ST_ISSUE:   if (io_ack)         state_nxt = ST_RESPOND;
            ST_RESPOND: if (!cpu_req)       state_nxt = ST_IDLE;
            default:                        state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        io_req   = (state == ST_ISSUE);
        cpu_ack  = (state == ST_RESPOND);
        load_req = (state == ST_IDLE) && cpu_req && hit;
        load_rsp = (state == ST_ISSUE) && io_ack;
    end

endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 16,
    parameter logic [ADDR_W-1:0] WINDOW_BASE = 32'h1400_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              io_req,
    output logic              io_we,
    output logic [1:0]        io_size,
    output logic [PORT_W-1:0] io_port,
    output logic [DATA_W-1:0] io_wdata,
    input  logic              io_ack,
    input  logic [DATA_W-1:0] io_rdata
);
    import isa_bridge_pkg::*;

    xfer_size_e        req_size, held_size;
    logic              hit, load_req, load_rsp;
    logic [PORT_W-1:0] dec_port;
    logic [DATA_W-1:0] wr_lanes, rd_lanes;

    logic [PORT_W-1:0] port_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    assign req_size = xfer_size_e'(cpu_size);

    isa_window_decode #(
        .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WINDOW_BASE(WINDOW_BASE)
    ) u_decode (
        .addr(cpu_addr), .size(req_size), .hit(hit), .port(dec_port)
    );

    isa_lane_shuffle #(.DATA_W(DATA_W)) u_wr_shuffle (
        .swap(big_endian), .size(req_size), .din(cpu_wdata), .dout(wr_lanes)
    );

    isa_lane_shuffle #(.DATA_W(DATA_W)) u_rd_shuffle (
        .swap(big_endian), .size(held_size), .din(io_rdata), .dout(rd_lanes)
    );

    isa_bridge_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .hit(hit),
        .io_ack(io_ack), .io_req(io_req), .cpu_ack(cpu_ack),
        .load_req(load_req), .load_rsp(load_rsp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q    <= '0;
            we_q      <= 1'b0;
            held_size <= XFER_BYTE;
            wdata_q   <= '0;
            rdata_q   <= '0;
        end else begin
            if (load_req) begin
                port_q    <= dec_port;
                we_q      <= cpu_we;
                held_size <= req_size;
                wdata_q   <= wr_lanes;
            end
            if (load_rsp) rdata_q <= rd_lanes;
        end
    end

    assign io_port   = port_q;
    assign io_we     = we_q;
    assign io_size   = held_size;
    assign io_wdata  = wdata_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/isa_io_bridge_checker.sv
module isa_io_bridge_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 16,
    parameter logic [ADDR_W-1:0] WINDOW_BASE = 32'h1400_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [1:0]        cpu_size,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ack,
    input logic              io_req,
    input logic              io_ack,
    input logic [1:0]        io_size,
    input logic [PORT_W-1:0] io_port,
    input logic [DATA_W-1:0] io_wdata
);
    logic claimable;
    assign claimable = ((cpu_addr >> PORT_W) == (WINDOW_BASE >> PORT_W)) && (cpu_size != 2'd3);

    AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> io_req); // R8

    AST_IO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> ($stable(io_port) && $stable(io_wdata) && $stable(io_size))); // R8

    AST_ACK_AFTER_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ack) |-> $past(io_req && io_ack)); // R9

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req && cpu_ack)); // R9

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_req) |=> cpu_ack); // R9

    AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_req && !cpu_ack && cpu_req && !claimable) |=> !io_req); // R1

    AST_PORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_req) |-> (io_port == $past(cpu_addr[PORT_W-1:0]))); // R2

endmodule

bind isa_io_bridge isa_io_bridge_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W), .WINDOW_BASE(WINDOW_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .io_req(io_req), .io_ack(io_ack),
    .io_size(io_size), .io_port(io_port), .io_wdata(io_wdata)
);

// File: tb/isa_io_bridge_test.sv
`timescale 1ns/1ps
module isa_io_bridge_test;

    typedef struct packed {
        logic        be;
        logic        we;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] dev;
        logic [15:0] port;
        logic [31:0] expd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd2, 32'h1400_03F8, 32'h1122_3344, 32'h0, 16'h03F8, 32'h1122_3344}, // R4
        '{1'b1, 1'b1, 2'd2, 32'h1400_0300, 32'h1122_3344, 32'h0, 16'h0300, 32'h4433_2211}, // R6
        '{1'b1, 1'b1, 2'd1, 32'h1400_FFFE, 32'hAABB_CCDD, 32'h0, 16'hFFFE, 32'h0000_DDCC}, // R5
        '{1'b1, 1'b1, 2'd0, 32'h1400_0001, 32'hAABB_CCDD, 32'h0, 16'h0001, 32'h0000_00DD}, // R7
        '{1'b1, 1'b0, 2'd2, 32'h1400_1234, 32'h0, 32'hDEAD_BEEF, 16'h1234, 32'hEFBE_ADDE}, // R6
        '{1'b1, 1'b0, 2'd1, 32'h1400_0010, 32'h0, 32'h1234_5678, 16'h0010, 32'h0000_7856}, // R5
        '{1'b1, 1'b0, 2'd0, 32'h1400_0000, 32'h0, 32'h1234_56A5, 16'h0000, 32'h0000_00A5}, // R7
        '{1'b0, 1'b0, 2'd1, 32'h1400_8000, 32'h0, 32'h1234_5678, 16'h8000, 32'h0000_5678}, // R4
        '{1'b0, 1'b0, 2'd2, 32'h1400_FFFC, 32'h0, 32'hCAFE_F00D, 16'hFFFC, 32'hCAFE_F00D}, // R4
        '{1'b0, 1'b1, 2'd1, 32'h1400_0002, 32'h89AB_CDEF, 32'h0, 16'h0002, 32'h0000_CDEF}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        io_req;
    logic        io_we;
    logic [1:0]  io_size;
    logic [15:0] io_port;
    logic [31:0] io_wdata;
    logic        io_ack = 1'b0;
    logic [31:0] io_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    isa_io_bridge uut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .io_req(io_req), .io_we(io_we),
        .io_size(io_size), .io_port(io_port), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_rdata(io_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One claimed access; the device acks after ack_delay cycles of io_req.
    task automatic run_access(input vec_t v, input int ack_delay, input int hold_after);
        int waited;
        @(negedge clk);
        big_endian = v.be; cpu_we = v.we; cpu_size = v.size;
        cpu_addr = v.addr; cpu_wdata = v.wdata; cpu_req = 1'b1;
        waited = 0;
        @(negedge clk);
        while (!io_req && waited < 20) begin
            waited++;
            @(negedge clk);
        end
        check(waited == 0 && io_req, "R8 io_req one cycle after claim", 32'(waited), 32'd0);
        check(io_port == v.port, "R2 port address", 32'(io_port), 32'(v.port));
        check(io_we == v.we && io_size == v.size, "R3 size and direction",
              {28'd0, io_we, 1'b0, io_size}, {28'd0, v.we, 1'b0, v.size});
        if (v.we) check(io_wdata == v.expd, "R4-R7 write lanes", io_wdata, v.expd);
        for (int k = 0; k < ack_delay; k++) begin
            @(negedge clk);
            check(io_req && !cpu_ack, "R8 hold until io_ack", {30'd0, io_req, cpu_ack}, 32'd2);
        end
        io_ack = 1'b1; io_rdata = v.dev;
        @(negedge clk);
        io_ack = 1'b0; io_rdata = 32'hFFFF_FFFF;
        check(cpu_ack && !io_req, "R9 ack after port completion", {30'd0, cpu_ack, io_req}, 32'd2);
        if (!v.we) check(cpu_rdata == v.expd, "R4-R7 read lanes", cpu_rdata, v.expd);
        for (int k = 0; k < hold_after; k++) begin
            @(negedge clk);
            check(cpu_ack && !io_req, "R9 single access while request held",
                  {30'd0, cpu_ack, io_req}, 32'd2);
        end
        cpu_req = 1'b0;
        @(negedge clk);
        check(!cpu_ack && !io_req, "R9 release", {30'd0, cpu_ack, io_req}, 32'd0);
    endtask

    task automatic run_miss(input logic [31:0] addr, input logic [1:0] size);
        int seen;
        seen = 0;
        @(negedge clk);
        big_endian = 1'b1; cpu_we = 1'b1; cpu_size = size;
        cpu_addr = addr; cpu_wdata = 32'h5555_AAAA; cpu_req = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (io_req || cpu_ack) seen++;
        end
        check(seen == 0, "R1 unclaimed request ignored", 32'(seen), 32'd0);
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!io_req && !cpu_ack, "R10 during reset", {30'd0, io_req, cpu_ack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_req && !cpu_ack, "R10 after reset", {30'd0, io_req, cpu_ack}, 32'd0);

        for (int i = 0; i < NV; i++) run_access(VECS[i], 0, 0);

        // slow device, CPU keeps request up after ack
        run_access('{1'b1, 1'b0, 2'd2, 32'h1400_0064, 32'h0, 32'h0102_0304, 16'h0064, 32'h0403_0201}, 3, 3); // R9 R6

        run_miss(32'h13FF_FFFF, 2'd2); // R1 below window
        run_miss(32'h1401_0000, 2'd1); // R1 above window
        run_miss(32'h1400_0040, 2'd3); // R1 R3 reserved size

        // claimed access still works after ignored traffic
        run_access('{1'b0, 1'b0, 2'd0, 32'h1400_0061, 32'h0, 32'hFFFF_FF3C, 16'h0061, 32'h0000_003C}, 1, 0); // R7 R4

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            finish_run();
        end
    end

endmodule